// File: doc/BRIEF.md
# Load/Store Port Request Master

This block sits between a load/store controller and a memory port. It takes one command at a time: load or store, a 4-bit byte length, an address and store data, plus two side flags (zero the cache line, bypass the cache). It then drives the port's request lines according to the port's busy protocol. The port is not fire-and-forget. The master holds the request, the address-valid flag and the address steady until the port releases busy. It waits for either an address acknowledge or an exception. After an acknowledge, a store sends a single store-valid strobe with its data. A load waits for the one-cycle data strobe and captures the data on that cycle.

Completion timing depends on the kind of access. An exception or the load data strobe ends the access in the cycle it arrives, and busy falls in that same cycle. A store ends only when busy has fallen, in the cycle after the store strobe or later. When the master leaves a transaction, it gives the controller a one-cycle done pulse with an error bit, plus the captured load data. A cancel input aborts a transaction in progress and pulses the port's abort line for one cycle.

Top module: `ldst_port_master`

## Requirements
- R1: A command (`cmd_valid_i`) is accepted only in a cycle where the master is idle and `pt_busy_i` is low. `cmd_ready_o` is high exactly then. A command offered while busy is high raises no request line.
- R2: Starting the cycle after a command is accepted, exactly one of `pt_is_ld_o` / `pt_is_st_o` is high, chosen by `cmd_store_i` (1 = store). The line stays high until the transaction ends. The two lines are never high together.
- R3: `pt_addr_ok_o` rises in the same cycle as the request line, with `pt_addr_o` equal to the accepted address. Both stay constant until the transaction ends.
- R4: For a store, `pt_st_ok_o` is high for exactly one cycle: the cycle after the one in which `pt_addr_ack_i` was sampled high. `pt_st_data_o` carries the accepted store data in that cycle. The strobe is never raised before the acknowledge.
- R5: For a load, a `pt_ld_ok_i` sampled high after the acknowledge captures `pt_ld_data_i`. In the next cycle `done_o`=1, `done_err_o`=0 and `ld_data_o` holds the captured word, and `pt_is_ld_o` is low.
- R6: After the store strobe, the master holds the request until `pt_busy_i` is sampled low. `done_o`=1 with `done_err_o`=0 follows one cycle after that sample and not before.
- R7: A `pt_exc_i` sampled high while waiting for the acknowledge or for load data ends the transaction. In the next cycle `done_o`=1 and `done_err_o`=1, and the request lines are low.
- R8: While a transaction is in progress, `cancel_i` drives `pt_go_die_o` high in the same cycle. In the next cycle the master is idle with request lines low, and `done_o`=1 with `done_err_o`=1. In idle, `pt_go_die_o` stays low.
- R9: `pt_len_o`, `pt_zero_line_o` and `pt_nocache_o` present the values accepted with the command for as long as the request is held.
- R10: A `pt_ld_ok_i` pulse that arrives before the address acknowledge is ignored. Only the strobe after the acknowledge supplies `ld_data_o`.
- R11: After reset the master is idle. `cmd_ready_o`=1, no request line is high, and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Controller offers a command |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_len_i | input | LEN_W | Byte length |
| cmd_addr_i | input | ADDR_W | Access address |
| cmd_data_i | input | DATA_W | Store data |
| cmd_zero_line_i | input | 1 | Cache-line zeroing flag, passed through |
| cmd_nocache_i | input | 1 | Non-cacheable flag, passed through |
| cancel_i | input | 1 | Abort the transaction in progress |
| cmd_ready_o | output | 1 | Command would be accepted this cycle |
| done_o | output | 1 | One-cycle transaction end pulse |
| done_err_o | output | 1 | End was an exception or cancel |
| ld_data_o | output | DATA_W | Captured load data |
| pt_busy_i | input | 1 | Port busy |
| pt_is_ld_o | output | 1 | Load request |
| pt_is_st_o | output | 1 | Store request |
| pt_len_o | output | LEN_W | Byte length to port |
| pt_zero_line_o | output | 1 | Cache-line zeroing flag to port |
| pt_nocache_o | output | 1 | Non-cacheable flag to port |
| pt_addr_ok_o | output | 1 | Address valid |
| pt_addr_o | output | ADDR_W | Address to port |
| pt_addr_ack_i | input | 1 | Address acknowledge pulse |
| pt_exc_i | input | 1 | Exception pulse |
| pt_ld_ok_i | input | 1 | Load data valid pulse |
| pt_ld_data_i | input | DATA_W | Load data |
| pt_st_ok_o | output | 1 | Store data valid pulse |
| pt_st_data_o | output | DATA_W | Store data to port |
| pt_go_die_o | output | 1 | Abort line to port |

## Verification
The bench issues loads with different acknowledge and data delays. This shows that capture is tied to the data strobe and not to a fixed latency. A stray data strobe before the acknowledge shows that early strobes are ignored. Stores are run once with busy dropping right after the strobe and once with busy held for extra cycles, which separates "done after busy falls" from "done a fixed cycle after the strobe". Exceptions arrive in the acknowledge wait and in the load-data wait. Cancels hit a load and a store in progress. A command offered while the port is still busy shows that no request is raised until busy clears.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_ACK  = 3'd1,
    ST_WAIT_LD   = 3'd2,
    ST_SEND_ST   = 3'd3,
    ST_WAIT_DROP = 3'd4
  } ldst_state_e;
endpackage

// File: rtl/ldst_cmd_reg.sv
module ldst_cmd_reg #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              store_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              zero_line_i,
  input  logic              nocache_i,
  output logic              store_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              zero_line_o,
  output logic              nocache_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      store_o     <= 1'b0;
      len_o       <= '0;
      addr_o      <= '0;
      data_o      <= '0;
      zero_line_o <= 1'b0;
      nocache_o   <= 1'b0;
    end else if (load_i) begin
      store_o     <= store_i;
      len_o       <= len_i;
      addr_o      <= addr_i;
      data_o      <= data_i;
      zero_line_o <= zero_line_i;
      nocache_o   <= nocache_i;
    end
  end
endmodule

// File: rtl/ldst_ld_capture.sv
module ldst_ld_capture #(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_o <= '0;
    else if (capture_i) data_o <= data_i;
  end
endmodule

// File: rtl/ldst_fsm.sv
module ldst_fsm
  import ldst_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic        is_store_i,
  input  logic        cancel_i,
  input  logic        busy_i,
  input  logic        ack_i,
  input  logic        exc_i,
  input  logic        ld_ok_i,
  output ldst_state_e state_o,
  output logic        accept_o,
  output logic        capture_o,
  output logic        done_o,
  output logic        done_err_o
);
  ldst_state_e state_q, state_d;
  logic fin, fin_err;

  assign accept_o = (state_q == ST_IDLE) && cmd_valid_i && !busy_i;

  always_comb begin
    state_d   = state_q;
    fin       = 1'b0;
    fin_err   = 1'b0;
    capture_o = 1'b0;
    if (state_q != ST_IDLE && cancel_i) begin
      state_d = ST_IDLE;
      fin     = 1'b1;
      fin_err = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE:     if (accept_o) state_d = ST_WAIT_ACK;
        ST_WAIT_ACK: begin
          if (exc_i) begin
            state_d = ST_IDLE; fin = 1'b1; fin_err = 1'b1;
          end else if (ack_i) begin
            state_d = is_store_i ? ST_SEND_ST : ST_WAIT_LD;
          end
        end
        ST_WAIT_LD: begin
          if (exc_i) begin
            state_d = ST_IDLE; fin = 1'b1; fin_err = 1'b1;
          end else if (ld_ok_i) begin
            state_d = ST_IDLE; fin = 1'b1; capture_o = 1'b1;
          end
        end
        ST_SEND_ST:   state_d = ST_WAIT_DROP;
        ST_WAIT_DROP: begin
          if (exc_i) begin
            state_d = ST_IDLE; fin = 1'b1; fin_err = 1'b1;
          end else if (!busy_i) begin
            state_d = ST_IDLE; fin = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      done_o     <= 1'b0;
      done_err_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      done_o     <= fin;
      done_err_o <= fin_err;
    end
  end

  assign state_o = state_q;

  AST_EXC_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i && !cancel_i && (state_q == ST_WAIT_ACK || state_q == ST_WAIT_LD))
      |=> (done_o && done_err_o)); // R7
  AST_LD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_LD && ld_ok_i && !exc_i && !cancel_i)
      |=> (done_o && !done_err_o)); // R5
  AST_EARLY_LD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_ACK && ld_ok_i) |=> !done_o || done_err_o); // R10
endmodule

// File: rtl/ldst_port_master.sv
module ldst_port_master
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_store_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_zero_line_i,
  input  logic              cmd_nocache_i,
  input  logic              cancel_i,
  output logic              cmd_ready_o,
  output logic              done_o,
  output logic              done_err_o,
  output logic [DATA_W-1:0] ld_data_o,
  input  logic              pt_busy_i,
  output logic              pt_is_ld_o,
  output logic              pt_is_st_o,
  output logic [LEN_W-1:0]  pt_len_o,
  output logic              pt_zero_line_o,
  output logic              pt_nocache_o,
  output logic              pt_addr_ok_o,
  output logic [ADDR_W-1:0] pt_addr_o,
  input  logic              pt_addr_ack_i,
  input  logic              pt_exc_i,
  input  logic              pt_ld_ok_i,
  input  logic [DATA_W-1:0] pt_ld_data_i,
  output logic              pt_st_ok_o,
  output logic [DATA_W-1:0] pt_st_data_o,
  output logic              pt_go_die_o
);
  ldst_state_e state;
  logic accept, capture, is_store, active;
  logic [DATA_W-1:0] st_data;

  ldst_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .is_store_i (is_store),
    .cancel_i   (cancel_i),
    .busy_i     (pt_busy_i),
    .ack_i      (pt_addr_ack_i),
    .exc_i      (pt_exc_i),
    .ld_ok_i    (pt_ld_ok_i),
    .state_o    (state),
    .accept_o   (accept),
    .capture_o  (capture),
    .done_o     (done_o),
    .done_err_o (done_err_o)
  );

  ldst_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .store_i    (cmd_store_i),
    .len_i      (cmd_len_i),
    .addr_i     (cmd_addr_i),
    .data_i     (cmd_data_i),
    .zero_line_i(cmd_zero_line_i),
    .nocache_i  (cmd_nocache_i),
    .store_o    (is_store),
    .len_o      (pt_len_o),
    .addr_o     (pt_addr_o),
    .data_o     (st_data),
    .zero_line_o(pt_zero_line_o),
    .nocache_o  (pt_nocache_o)
  );

  ldst_ld_capture #(.DATA_W(DATA_W)) u_ld (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(capture),
    .data_i   (pt_ld_data_i),
    .data_o   (ld_data_o)
  );

  // request, address and flags are held for the whole transaction
  assign active       = (state != ST_IDLE);
  assign cmd_ready_o  = !active && !pt_busy_i;
  assign pt_is_ld_o   = active && !is_store;
  assign pt_is_st_o   = active && is_store;
  assign pt_addr_ok_o = active;
  assign pt_st_ok_o   = (state == ST_SEND_ST);
  assign pt_st_data_o = st_data;
  assign pt_go_die_o  = active && cancel_i;

  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_busy_i && !pt_is_ld_o && !pt_is_st_o) |=> (!pt_is_ld_o && !pt_is_st_o)); // R1
  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pt_is_ld_o && pt_is_st_o)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_addr_ok_o && $past(pt_addr_ok_o)) |-> $stable(pt_addr_o)); // R3
  AST_ST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_st_ok_o |=> !pt_st_ok_o); // R4
  AST_ST_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pt_st_ok_o) |-> $past(pt_addr_ack_i)); // R4
  AST_GO_DIE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_go_die_o |=> (!pt_is_ld_o && !pt_is_st_o && done_err_o)); // R8
endmodule

// File: tb/ldst_port_master_test.sv
module ldst_port_master_test;
  localparam int AW = 64;
  localparam int DW = 64;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cmd_valid = 0, cmd_store = 0, zl = 0, nc = 0, cancel = 0;
  logic [LW-1:0] cmd_len = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic busy = 0, ack = 0, exc = 0, ld_ok = 0;
  logic [DW-1:0] ld_data_in = '0;
  logic cmd_ready, done, done_err, is_ld, is_st, zl_o, nc_o, addr_ok, st_ok, go_die;
  logic [DW-1:0] ld_data, st_data;
  logic [LW-1:0] len_o;
  logic [AW-1:0] addr_o;

  ldst_port_master #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_store_i(cmd_store), .cmd_len_i(cmd_len),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .cmd_zero_line_i(zl),
    .cmd_nocache_i(nc), .cancel_i(cancel), .cmd_ready_o(cmd_ready),
    .done_o(done), .done_err_o(done_err), .ld_data_o(ld_data),
    .pt_busy_i(busy), .pt_is_ld_o(is_ld), .pt_is_st_o(is_st), .pt_len_o(len_o),
    .pt_zero_line_o(zl_o), .pt_nocache_o(nc_o), .pt_addr_ok_o(addr_ok),
    .pt_addr_o(addr_o), .pt_addr_ack_i(ack), .pt_exc_i(exc), .pt_ld_ok_i(ld_ok),
    .pt_ld_data_i(ld_data_in), .pt_st_ok_o(st_ok), .pt_st_data_o(st_data),
    .pt_go_die_o(go_die)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic           exp_err_q[$];
  logic           exp_chk_q[$];
  logic [DW-1:0]  exp_dat_q[$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: each done pulse pops one expected result
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_err_q.size() == 0) begin
        chk("R6 unexpected done", 1, 0);
      end else begin
        logic e, c;
        logic [DW-1:0] d;
        e = exp_err_q.pop_front();
        c = exp_chk_q.pop_front();
        d = exp_dat_q.pop_front();
        chk("R5/R6/R7/R8 done_err", {63'd0, done_err}, {63'd0, e});
        if (c) chk("R5 ld_data", ld_data, d);
      end
    end
  end

  task automatic expect_done(logic e, logic c, logic [DW-1:0] d);
    exp_err_q.push_back(e);
    exp_chk_q.push_back(c);
    exp_dat_q.push_back(d);
  endtask

  // drive a command; on return the request is visible and busy is high
  task automatic issue(logic st, logic [AW-1:0] a, logic [LW-1:0] l, logic [DW-1:0] d,
                       logic z, logic n);
    @(negedge clk);
    cmd_valid = 1; cmd_store = st; cmd_addr = a; cmd_len = l; cmd_data = d; zl = z; nc = n;
    #1 chk("R1 ready", {63'd0, cmd_ready}, 64'd1);
    @(negedge clk);
    cmd_valid = 0; cmd_addr = '1; cmd_len = '0; cmd_data = '0; zl = 0; nc = 0;
    busy = 1;
    chk("R2 request line", {62'd0, is_ld, is_st}, st ? 64'd1 : 64'd2);
    chk("R3 addr_ok", {63'd0, addr_ok}, 64'd1);
    chk("R3 addr", addr_o, a);
    chk("R9 len/flags", {58'd0, len_o, zl_o, nc_o}, {58'd0, l, z, n});
  endtask

  task automatic pulse_ack(int dly);
    repeat (dly) begin
      @(negedge clk);
      chk("R3 addr held", {63'd0, addr_ok}, 64'd1);
    end
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic do_load(logic [AW-1:0] a, logic [DW-1:0] d, int adly, int ddly, bit early);
    issue(0, a, 4'd8, '0, 0, 1);
    expect_done(0, 1, d);
    if (early) begin
      @(negedge clk); ld_ok = 1; ld_data_in = ~d;
      @(negedge clk); ld_ok = 0;
      chk("R10 early strobe ignored", {63'd0, is_ld}, 64'd1);
    end
    pulse_ack(adly);
    repeat (ddly) @(negedge clk);
    ld_ok = 1; ld_data_in = d; busy = 0;
    @(negedge clk); ld_ok = 0; ld_data_in = '0;
    chk("R5 request dropped", {63'd0, is_ld}, 64'd0);
  endtask

  task automatic do_store(logic [AW-1:0] a, logic [DW-1:0] d, int hold);
    issue(1, a, 4'd4, d, 1, 0);
    expect_done(0, 0, '0);
    pulse_ack(1);
    chk("R4 st_ok after ack", {63'd0, st_ok}, 64'd1);
    chk("R4 st_data", st_data, d);
    @(negedge clk);
    chk("R4 single pulse", {63'd0, st_ok}, 64'd0);
    repeat (hold) begin
      chk("R6 no done while busy", {63'd0, done}, 64'd0);
      chk("R6 store held", {63'd0, is_st}, 64'd1);
      @(negedge clk);
    end
    busy = 0;
    @(negedge clk);
    chk("R6 request dropped", {63'd0, is_st}, 64'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset ready", {63'd0, cmd_ready}, 64'd1);
    chk("R11 reset idle", {61'd0, is_ld, is_st, done}, 64'd0);

    do_load(64'h1000_0000_0000_0040, 64'hDEAD_BEEF_0123_4567, 0, 0, 0);
    do_load(64'h0000_0000_0000_0A18, 64'h5555_AAAA_0F0F_F0F0, 3, 4, 0);
    do_load(64'h0000_0000_0000_0200, 64'h1122_3344_5566_7788, 1, 2, 1);
    do_store(64'h0000_0000_0000_0100, 64'hCAFE_F00D_0000_0001, 0);
    do_store(64'h0000_0000_0000_0108, 64'h0BAD_0BAD_FFFF_0000, 3);

    // R7: exception while waiting for acknowledge
    issue(0, 64'h40, 4'd2, '0, 0, 0);
    expect_done(1, 0, '0);
    @(negedge clk); exc = 1; busy = 0;
    @(negedge clk); exc = 0;
    chk("R7 ends on exc", {62'd0, is_ld, is_st}, 64'd0);

    // R7: exception while waiting for load data
    issue(0, 64'h48, 4'd2, '0, 0, 0);
    expect_done(1, 0, '0);
    pulse_ack(0);
    exc = 1; busy = 0;
    @(negedge clk); exc = 0;
    chk("R7 ends on exc in data wait", {62'd0, is_ld, is_st}, 64'd0);

    // R8: cancel a load
    issue(0, 64'h50, 4'd1, '0, 0, 0);
    expect_done(1, 0, '0);
    @(negedge clk); cancel = 1;
    #1 chk("R8 go_die", {63'd0, go_die}, 64'd1);
    @(negedge clk); cancel = 0; busy = 0;
    #1 chk("R8 go_die single", {63'd0, go_die}, 64'd0);
    chk("R8 idle after cancel", {62'd0, is_ld, is_st}, 64'd0);

    // R8: cancel a store after acknowledge
    issue(1, 64'h58, 4'd8, 64'h77, 0, 0);
    expect_done(1, 0, '0);
    pulse_ack(0);
    @(negedge clk);
    cancel = 1;
    #1 chk("R8 go_die store", {63'd0, go_die}, 64'd1);
    @(negedge clk); cancel = 0; busy = 0;
    chk("R8 store idle", {62'd0, is_ld, is_st}, 64'd0);

    // R8: cancel in idle has no effect
    @(negedge clk); cancel = 1;
    #1 chk("R8 no go_die in idle", {63'd0, go_die}, 64'd0);
    @(negedge clk); cancel = 0;

    // R1: command held off by busy
    busy = 1; cmd_valid = 1; cmd_store = 0; cmd_addr = 64'h60; cmd_len = 4'd8;
    #1 chk("R1 not ready while busy", {63'd0, cmd_ready}, 64'd0);
    repeat (2) @(negedge clk);
    chk("R1 no request while busy", {62'd0, is_ld, is_st}, 64'd0);
    cmd_valid = 0; busy = 0;
    do_load(64'h68, 64'h0102_0304_0506_0708, 0, 1, 0);

    repeat (3) @(negedge clk);
    chk("R6 all results seen", exp_err_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule